// File: doc/BRIEF.md
# Status Event Register Group

This block collects two live status flags into a 16-bit condition register and turns their changes into latched events. Each bit passes through a transition filter with a rising-edge mask and a falling-edge mask, so a bit can report entering a state, leaving it, or both. Latched events are gated by an enable register. The OR of all enabled events drives one registered summary line, which a higher-level status register can take in as one of its own inputs.

A host reaches the group through a small strobe-based register port. The host can write and read both transition masks and the enable register. It can read the condition register. It can read the event register, and that read clears the event register. Bit 15 of every register is tied to zero.

Top module: `stat_evt_group`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the registers hold these values: condition 0, falling mask 0, events 0, enable 0, rising mask 0x7FFF. `summary` is 0.
- R2: A read at address 0 returns the condition register. Bit 1 is the value `lay1_flag` had at the previous rising clock edge, bit 2 is the same for `lay2_flag`, and every other bit is 0.
- R3: If a condition bit goes from 0 to 1 while the matching bit of the rising mask (address 1) is 1, the matching event bit is set from the next clock onward.
- R4: If a condition bit goes from 1 to 0 while the matching bit of the falling mask (address 2) is 1, the matching event bit is set from the next clock onward.
- R5: An edge whose mask bit is 0 leaves the event register unchanged.
- R6: An event bit stays set until the host reads address 3. That read returns the current events on `rdata` in the same cycle and clears all event bits at the next edge. An edge that is filtered in during that same cycle is still latched.
- R7: `summary` is the OR over all bits of (event AND enable), registered. It follows changes in the event or enable register one clock later.
- R8: Bit 15 reads as 0 in every register, and writing 1 to it has no effect.
- R9: Writes at addresses 1, 2 and 4 (rising mask, falling mask, enable) take effect at the next edge and read back. Reading these registers does not change them.
- R10: Writes to address 0, address 3 and addresses 5–7 have no effect. Reads of addresses 5–7 return 0. `rdata` is 0 whenever `rd_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lay1_flag | input | 1 | Live layer-1 status flag, synchronous to `clk` |
| lay2_flag | input | 1 | Live layer-2 status flag, synchronous to `clk` |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| addr | input | 3 | Register select: 0 condition, 1 rising mask, 2 falling mask, 3 events, 4 enable |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle `rd_stb` is high |
| summary | output | 1 | Registered OR of enabled events |

## Verification
The assertions assume that both status flags and all host signals are synchronous to `clk` and stable around each rising edge. They also assume a strobe describes one access in the cycle it is high. The bench changes every input only on the falling edge and samples outputs two nanoseconds later, so no input ever changes near a rising edge. The bench's randomized phase raises or lowers the strobes on any cycle, including back-to-back cycles and cycles that also carry flag edges. Each cycle stands on its own as one access.

// File: rtl/stat_evt_pkg.sv
package stat_evt_pkg;

    localparam int REG_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int TOP_BIT = REG_W - 1;
    localparam int LAY1_POS = 1;
    localparam int LAY2_POS = 2;

    typedef logic [REG_W-1:0]  sreg_t;
    typedef logic [ADDR_W-1:0] saddr_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COND = 3'd0,
        SEL_RISE = 3'd1,
        SEL_FALL = 3'd2,
        SEL_EVT  = 3'd3,
        SEL_EN   = 3'd4
    } reg_sel_e;

    // filtered edges seen on the live status vector
    typedef struct packed {
        sreg_t rise;
        sreg_t fall;
    } edge_t;

    // host write request as seen by the configuration registers
    typedef struct packed {
        logic   wr;
        saddr_t addr;
        sreg_t  data;
    } host_wr_t;

    localparam sreg_t WRITABLE = sreg_t'((32'd1 << TOP_BIT) - 32'd1);

    function automatic sreg_t drop_top(sreg_t v);
        return v & WRITABLE;
    endfunction

    function automatic sreg_t pack_status(logic l1, logic l2);
        sreg_t v;
        v = '0;
        v[LAY1_POS] = l1;
        v[LAY2_POS] = l2;
        return v;
    endfunction

endpackage

// File: rtl/stat_cond_edge.sv
module stat_cond_edge
    import stat_evt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sreg_t live,
    output sreg_t cond_q,
    output edge_t edges
);

    always_ff @(posedge clk) begin
        if (rst) cond_q <= '0;
        else     cond_q <= live;
    end

    always_comb begin
        edges.rise = live & ~cond_q;
        edges.fall = ~live & cond_q;
    end

endmodule

// File: rtl/stat_cfg_regs.sv
module stat_cfg_regs
    import stat_evt_pkg::*;
#(
    parameter sreg_t RISE_RST = WRITABLE,
    parameter sreg_t FALL_RST = '0,
    parameter sreg_t EN_RST   = '0
)(
    input  logic     clk,
    input  logic     rst,
    input  host_wr_t req,
    output sreg_t    rise_q,
    output sreg_t    fall_q,
    output sreg_t    en_q
);

    localparam int NREG = 3;
    localparam sreg_t    RST_VAL [NREG] = '{drop_top(RISE_RST), drop_top(FALL_RST), drop_top(EN_RST)};
    localparam reg_sel_e SEL_VAL [NREG] = '{SEL_RISE, SEL_FALL, SEL_EN};

    sreg_t cfg_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[i] <= RST_VAL[i];
            else if (req.wr && (req.addr == SEL_VAL[i]))
                cfg_q[i] <= drop_top(req.data);
        end
    end

    assign rise_q = cfg_q[0];
    assign fall_q = cfg_q[1];
    assign en_q   = cfg_q[2];

endmodule

// File: rtl/stat_evt_latch.sv
module stat_evt_latch
    import stat_evt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  edge_t edges,
    input  sreg_t rise_mask,
    input  sreg_t fall_mask,
    input  logic  clr,
    output sreg_t evt_q
);

    sreg_t hits;
    sreg_t kept;

    always_comb begin
        hits = drop_top((edges.rise & rise_mask) | (edges.fall & fall_mask));
        kept = clr ? '0 : evt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= kept | hits;
    end

endmodule

// File: rtl/stat_evt_group.sv
module stat_evt_group
    import stat_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lay1_flag,
    input  logic        lay2_flag,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        summary
);

    sreg_t    live_vec;
    sreg_t    cond_q;
    edge_t    edges;
    sreg_t    rise_q;
    sreg_t    fall_q;
    sreg_t    en_q;
    sreg_t    evt_q;
    host_wr_t wreq;
    logic     evt_rd;
    logic     summary_q;

    assign live_vec = pack_status(lay1_flag, lay2_flag);

    assign wreq.wr   = wr_stb;
    assign wreq.addr = addr;
    assign wreq.data = wdata;

    assign evt_rd = rd_stb && (addr == SEL_EVT);

    stat_cond_edge u_cond (
        .clk    (clk),
        .rst    (rst),
        .live   (live_vec),
        .cond_q (cond_q),
        .edges  (edges)
    );

    stat_cfg_regs u_cfg (
        .clk    (clk),
        .rst    (rst),
        .req    (wreq),
        .rise_q (rise_q),
        .fall_q (fall_q),
        .en_q   (en_q)
    );

    stat_evt_latch u_evt (
        .clk       (clk),
        .rst       (rst),
        .edges     (edges),
        .rise_mask (rise_q),
        .fall_mask (fall_q),
        .clr       (evt_rd),
        .evt_q     (evt_q)
    );

    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            case (reg_sel_e'(addr))
                SEL_COND: rdata = cond_q;
                SEL_RISE: rdata = rise_q;
                SEL_FALL: rdata = fall_q;
                SEL_EVT:  rdata = evt_q;
                SEL_EN:   rdata = en_q;
                default:  rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) summary_q <= 1'b0;
        else     summary_q <= |(evt_q & en_q);
    end

    assign summary = summary_q;

endmodule

// File: rtl/stat_evt_chk.sv
module stat_evt_chk
    import stat_evt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic [2:0]  addr,
    input logic [15:0] rdata,
    input logic        summary,
    input sreg_t       live,
    input sreg_t       cond_q,
    input sreg_t       rise_q,
    input sreg_t       fall_q,
    input sreg_t       en_q,
    input sreg_t       evt_q
);

    // R8
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rdata[TOP_BIT]);

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |-> (rdata == '0));

    // R2
    cond_unused_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && addr == SEL_COND) |-> (rdata[0] == 1'b0 && rdata[15:3] == '0));

    // R3
    rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|(live & ~cond_q & rise_q)) |=> (|evt_q));

    // R4
    fall_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|(~live & cond_q & fall_q)) |=> (|evt_q));

    // R5
    masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_q == '0 && fall_q == '0 && !(rd_stb && addr == SEL_EVT)) |=> (evt_q == $past(evt_q)));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && addr == SEL_EVT && live == cond_q) |=> (evt_q == '0));

    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && addr == SEL_EN) |=> $stable(en_q));

    // R7
    summary_low_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt_q & en_q) == '0) |=> !summary);

endmodule

bind stat_evt_group stat_evt_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .addr    (addr),
    .rdata   (rdata),
    .summary (summary),
    .live    (live_vec),
    .cond_q  (cond_q),
    .rise_q  (rise_q),
    .fall_q  (fall_q),
    .en_q    (en_q),
    .evt_q   (evt_q)
);

// File: tb/sim_stat_evt_group.sv
module sim_stat_evt_group;

    logic        clk;
    logic        rst;
    logic        lay1_flag;
    logic        lay2_flag;
    logic        wr_stb;
    logic        rd_stb;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        summary;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state
    int m_cond, m_rise, m_fall, m_ev, m_en, m_sum;
    logic [31:0] lf = 32'h1234_5678;

    stat_evt_group u0 (
        .clk(clk), .rst(rst), .lay1_flag(lay1_flag), .lay2_flag(lay2_flag),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr), .wdata(wdata),
        .rdata(rdata), .summary(summary)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata();
        if (!rd_stb) return 0;
        case (addr)
            3'd0: return m_cond;
            3'd1: return m_rise;
            3'd2: return m_fall;
            3'd3: return m_ev;
            3'd4: return m_en;
            default: return 0;
        endcase
    endfunction

    function automatic void model_clock();
        int st, rise, fall, ev_n, sum_n;
        if (rst) begin
            m_cond = 0; m_rise = 'h7FFF; m_fall = 0; m_ev = 0; m_en = 0; m_sum = 0;
            return;
        end
        st    = (int'(lay1_flag) << 1) | (int'(lay2_flag) << 2);
        rise  = st & ~m_cond;
        fall  = ~st & m_cond;
        ev_n  = ((rd_stb && addr == 3'd3) ? 0 : m_ev) | (rise & m_rise) | (fall & m_fall);
        ev_n  = ev_n & 'h7FFF;
        sum_n = ((m_ev & m_en) != 0) ? 1 : 0;
        if (wr_stb) begin
            if (addr == 3'd1) m_rise = int'(wdata) & 'h7FFF;
            if (addr == 3'd2) m_fall = int'(wdata) & 'h7FFF;
            if (addr == 3'd4) m_en   = int'(wdata) & 'h7FFF;
        end
        m_cond = st;
        m_ev   = ev_n;
        m_sum  = sum_n;
    endfunction

    // one cycle: inputs already set at the falling edge
    task automatic step(input string req);
        #2;
        chk(req, "rdata", int'(rdata), exp_rdata());
        chk("R7", "summary", int'(summary), m_sum);
        @(posedge clk);
        model_clock();
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        wr_stb = 0; rd_stb = 0; addr = 0; wdata = 0;
        step(req);
    endtask

    task automatic wr(input string req, input logic [2:0] a, input logic [15:0] d);
        wr_stb = 1; rd_stb = 0; addr = a; wdata = d;
        step(req);
        wr_stb = 0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input int expv);
        wr_stb = 0; rd_stb = 1; addr = a; wdata = 0;
        #2;
        chk(req, "read value", int'(rdata), expv);
        #0;
        step(req);
        rd_stb = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; lay1_flag = 0; lay2_flag = 0;
        wr_stb = 0; rd_stb = 0; addr = 0; wdata = 0;
        m_cond = 0; m_rise = 'h7FFF; m_fall = 0; m_ev = 0; m_en = 0; m_sum = 0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step("R1");
        rst = 0;
        // R1 reset values
        rd("R1", 3'd0, 0);
        rd("R1", 3'd1, 'h7FFF);
        rd("R1", 3'd2, 0);
        rd("R1", 3'd3, 0);
        rd("R1", 3'd4, 0);
        // R2 condition follows flags
        lay1_flag = 1; idle("R2");
        rd("R2", 3'd0, 'h0002);
        // R3 rising edge latched (bit 1), R6 read clears
        rd("R3", 3'd3, 'h0002);
        rd("R6", 3'd3, 0);
        // R7 enable and summary
        lay2_flag = 1; idle("R3");
        wr("R9", 3'd4, 'h0004);
        idle("R7");
        chk("R7", "summary high", int'(summary), 1);
        rd("R6", 3'd3, 'h0004);
        idle("R7");
        chk("R7", "summary low after clear", int'(summary), 0);
        // R4 falling edge with only falling mask
        wr("R9", 3'd1, 'h0000);
        wr("R9", 3'd2, 'h0004);
        rd("R9", 3'd2, 'h0004);
        lay2_flag = 0; idle("R4");
        lay1_flag = 0; idle("R5");
        rd("R4", 3'd3, 'h0004);
        // R5 masks zero: no events
        wr("R9", 3'd2, 'h0000);
        lay1_flag = 1; idle("R5");
        lay1_flag = 0; lay2_flag = 1; idle("R5");
        rd("R5", 3'd3, 0);
        // R6 edge in read cycle kept
        wr("R9", 3'd1, 'h0006);
        lay2_flag = 0; idle("R6");
        lay1_flag = 1; rd("R6", 3'd3, 0);
        rd("R6", 3'd3, 'h0002);
        // R8 top bit
        wr("R8", 3'd4, 'hFFFF);
        rd("R8", 3'd4, 'h7FFF);
        rd("R9", 3'd4, 'h7FFF);
        // R10 ignored writes and empty addresses
        wr("R10", 3'd0, 'hFFFF);
        wr("R10", 3'd3, 'hFFFF);
        wr("R10", 3'd5, 'hFFFF);
        rd("R10", 3'd0, 'h0002);
        rd("R10", 3'd3, 0);
        rd("R10", 3'd5, 0);
        rd("R10", 3'd6, 0);
        rd("R10", 3'd7, 0);
        rd("R9", 3'd1, 'h0006);
        // randomized traffic, checked every cycle against the model
        for (int i = 0; i < 400; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            lay1_flag = lf[0];
            lay2_flag = lf[3];
            rd_stb    = lf[6] & lf[7];
            wr_stb    = lf[8] & lf[9] & lf[10];
            addr      = lf[13:11];
            wdata     = lf[31:16];
            step("R7");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule